// File: doc/BRIEF.md
# Instruction Prefix Extension Unit

This decode-stage block widens the short fields of a 16-bit instruction word. A prefix instruction supplies three things: a high byte for the next immediate, a group of upper register-index bits, and the plain fact that a prefix is present. The unit holds these for exactly one cycle. The instruction decoded in that cycle gets a 16-bit immediate built from the held high byte and its own 8-bit immediate. It also gets destination and source register indexes that reach past the short encoded ranges. If it is a branch, it is marked absolute.

The holding logic is a two-state machine. **PX_EMPTY** means no prefix is held. **PX_LOADED** means a prefix was written on the previous clock edge. The machine has four transitions:
- **LOAD** (PX_EMPTY to PX_LOADED): taken on a prefix write.
- **IDLE** (PX_EMPTY to PX_EMPTY): taken when there is no write.
- **RELOAD** (PX_LOADED to PX_LOADED): taken when a new prefix is written while one is being used.
- **EXPIRE** (PX_LOADED to PX_EMPTY): taken when there is no write. The held data is cleared to zero on this transition.

The state is the "prefix present" flag. Because of this, a written 00h still makes a branch absolute, while an instruction with no prefix sees a zero high byte and is treated as a relative branch.

Top module: `pfx_ext_unit`

## Requirements
- R1: Reset returns the unit to PX_EMPTY with zero held data. After reset, the first decoded instruction sees a zero high byte, zero-extended indexes and a relative branch, even if a prefix was written just before reset.
- R2: When a prefix was written on the previous edge, `ext_imm` equals {held high byte, `ins_imm`}, with the prefix byte in bits 15:8.
- R3: When no prefix was written on the previous edge, `ext_imm[15:8]` is zero and `ext_imm[7:0]` equals `ins_imm`.
- R4: A prefix is visible for one cycle only. It expires on the next edge that carries no prefix write, whether or not an instruction used it.
- R5: `br_abs` is 1 for a decoded branch (`ins_branch`=1) exactly when a prefix was written on the previous edge. This includes a prefix byte of 00h.
- R6: A decoded branch with no preceding prefix write gives `br_abs`=0. A non-branch instruction always gives `br_abs`=0.
- R7: `ext_dst` equals {held index bits, `ins_dst`}, with `ins_dst` in bits 2:0. The upper bits are zero when no prefix is held.
- R8: `ext_src` equals {held index bits, `ins_src`}, with `ins_src` in bits 3:0. The upper bits are zero when no prefix is held.
- R9: When a prefix write and a decoded instruction fall in the same cycle, the instruction uses the older prefix (or none). The new prefix applies to the instruction in the following cycle.
- R10: While `dec_valid` is 0, `ext_imm`, `ext_dst`, `ext_src` and `br_abs` are all zero. A prefix write in that cycle is still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | An instruction is being decoded this cycle |
| ins_branch | input | 1 | The decoded instruction is a branch |
| ins_imm | input | 8 | Instruction immediate field |
| ins_dst | input | 3 | Instruction destination index field |
| ins_src | input | 4 | Instruction source index field |
| pfx_wr | input | 1 | Prefix write strobe |
| pfx_byte | input | 8 | Prefix high byte for the next immediate |
| pfx_idx | input | 4 | Prefix upper register-index bits |
| ext_imm | output | 16 | Extended immediate |
| ext_dst | output | 7 | Extended destination index |
| ext_src | output | 8 | Extended source index |
| br_abs | output | 1 | Branch is absolute (1) or relative (0) |

## Verification
The state register affects the outputs in the very next cycle after any error. If the machine stays in PX_LOADED when it should have expired, a stale high byte or `br_abs`=1 shows up on the next decoded instruction. If the machine drops to PX_EMPTY too early, a prefixed branch reads as relative in the same cycle. Two cases are checked directly: a 00h prefix followed by a branch, and a prefix written but never used. These are the two cases where a comparison on data alone, without the presence flag, would hide the fault.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int IMM_LO_W = 8;
    localparam int IMM_HI_W = 8;
    localparam int DST_FLD_W = 3;
    localparam int SRC_FLD_W = 4;
    localparam int IDX_HI_W = 4;

    typedef enum logic [0:0] {
        PX_EMPTY  = 1'b0,
        PX_LOADED = 1'b1
    } pfx_state_e;

endpackage

// File: rtl/pfx_hold.sv
// One-cycle prefix holder: state register plus the held byte and index bits.
module pfx_hold
    import pfx_pkg::*;
#(
    parameter int HI_W  = IMM_HI_W,
    parameter int IDX_W = IDX_HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfx_wr,
    input  logic [HI_W-1:0]  pfx_byte,
    input  logic [IDX_W-1:0] pfx_idx,
    output logic             held_vld,
    output logic [HI_W-1:0]  held_byte,
    output logic [IDX_W-1:0] held_idx
);

    pfx_state_e state_q, state_d;
    logic [HI_W-1:0]  byte_q, byte_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // Next-state and next-data logic
    always_comb begin
        state_d = state_q;
        byte_d  = '0;
        idx_d   = '0;
        unique case (state_q)
            PX_EMPTY: begin
                if (pfx_wr) begin
                    state_d = PX_LOADED;          // LOAD
                    byte_d  = pfx_byte;
                    idx_d   = pfx_idx;
                end else begin
                    state_d = PX_EMPTY;           // IDLE
                end
            end
            PX_LOADED: begin
                if (pfx_wr) begin
                    state_d = PX_LOADED;          // RELOAD
                    byte_d  = pfx_byte;
                    idx_d   = pfx_idx;
                end else begin
                    state_d = PX_EMPTY;           // EXPIRE: data clears
                end
            end
            default: state_d = PX_EMPTY;
        endcase
    end

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PX_EMPTY;
            byte_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            idx_q   <= idx_d;
        end
    end

    // Outputs
    always_comb begin
        held_vld  = (state_q == PX_LOADED);
        held_byte = byte_q;
        held_idx  = idx_q;
    end

endmodule

// File: rtl/pfx_merge.sv
// Combines the held prefix with the current instruction fields.
module pfx_merge
    import pfx_pkg::*;
#(
    parameter int LO_W  = IMM_LO_W,
    parameter int HI_W  = IMM_HI_W,
    parameter int DST_W = DST_FLD_W,
    parameter int SRC_W = SRC_FLD_W,
    parameter int IDX_W = IDX_HI_W
) (
    input  logic                   dec_valid,
    input  logic                   ins_branch,
    input  logic [LO_W-1:0]        ins_imm,
    input  logic [DST_W-1:0]       ins_dst,
    input  logic [SRC_W-1:0]       ins_src,
    input  logic                   held_vld,
    input  logic [HI_W-1:0]        held_byte,
    input  logic [IDX_W-1:0]       held_idx,
    output logic [HI_W+LO_W-1:0]   ext_imm,
    output logic [IDX_W+DST_W-1:0] ext_dst,
    output logic [IDX_W+SRC_W-1:0] ext_src,
    output logic                   br_abs
);

    logic [HI_W-1:0]  hi_sel;
    logic [IDX_W-1:0] idx_sel;

    always_comb begin
        hi_sel  = held_vld ? held_byte : '0;
        idx_sel = held_vld ? held_idx  : '0;
        if (dec_valid) begin
            ext_imm = {hi_sel, ins_imm};
            ext_dst = {idx_sel, ins_dst};
            ext_src = {idx_sel, ins_src};
            br_abs  = ins_branch & held_vld;
        end else begin
            ext_imm = '0;
            ext_dst = '0;
            ext_src = '0;
            br_abs  = 1'b0;
        end
    end

endmodule

// File: rtl/pfx_ext_unit.sv
module pfx_ext_unit
    import pfx_pkg::*;
#(
    parameter int LO_W  = IMM_LO_W,
    parameter int HI_W  = IMM_HI_W,
    parameter int DST_W = DST_FLD_W,
    parameter int SRC_W = SRC_FLD_W,
    parameter int IDX_W = IDX_HI_W,
    localparam int IMM_W  = HI_W + LO_W,
    localparam int EDST_W = IDX_W + DST_W,
    localparam int ESRC_W = IDX_W + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic              ins_branch,
    input  logic [LO_W-1:0]   ins_imm,
    input  logic [DST_W-1:0]  ins_dst,
    input  logic [SRC_W-1:0]  ins_src,
    input  logic              pfx_wr,
    input  logic [HI_W-1:0]   pfx_byte,
    input  logic [IDX_W-1:0]  pfx_idx,
    output logic [IMM_W-1:0]  ext_imm,
    output logic [EDST_W-1:0] ext_dst,
    output logic [ESRC_W-1:0] ext_src,
    output logic              br_abs
);

    logic             held_vld;
    logic [HI_W-1:0]  held_byte;
    logic [IDX_W-1:0] held_idx;

    pfx_hold #(.HI_W(HI_W), .IDX_W(IDX_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .pfx_wr    (pfx_wr),
        .pfx_byte  (pfx_byte),
        .pfx_idx   (pfx_idx),
        .held_vld  (held_vld),
        .held_byte (held_byte),
        .held_idx  (held_idx)
    );

    pfx_merge #(.LO_W(LO_W), .HI_W(HI_W), .DST_W(DST_W), .SRC_W(SRC_W), .IDX_W(IDX_W)) u_merge (
        .dec_valid  (dec_valid),
        .ins_branch (ins_branch),
        .ins_imm    (ins_imm),
        .ins_dst    (ins_dst),
        .ins_src    (ins_src),
        .held_vld   (held_vld),
        .held_byte  (held_byte),
        .held_idx   (held_idx),
        .ext_imm    (ext_imm),
        .ext_dst    (ext_dst),
        .ext_src    (ext_src),
        .br_abs     (br_abs)
    );

endmodule

// File: rtl/pfx_ext_chk.sv
module pfx_ext_chk #(
    parameter int LO_W  = 8,
    parameter int HI_W  = 8,
    parameter int DST_W = 3,
    parameter int SRC_W = 4,
    parameter int IDX_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dec_valid,
    input logic                   ins_branch,
    input logic [LO_W-1:0]        ins_imm,
    input logic [DST_W-1:0]       ins_dst,
    input logic [SRC_W-1:0]       ins_src,
    input logic                   pfx_wr,
    input logic [HI_W-1:0]        pfx_byte,
    input logic [HI_W+LO_W-1:0]   ext_imm,
    input logic [IDX_W+DST_W-1:0] ext_dst,
    input logic [IDX_W+SRC_W-1:0] ext_src,
    input logic                   br_abs
);

    // Set after the first edge out of reset, so $past never reaches into reset.
    logic up;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up <= 1'b0;
        else        up <= 1'b1;
    end

    a_r5_abs_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (up && br_abs) |-> $past(pfx_wr));

    a_r5_write_gives_abs: assert property (@(posedge clk) disable iff (!rst_n)
        (up && $past(pfx_wr) && dec_valid && ins_branch) |-> br_abs);

    a_r6_nonbranch_rel: assert property (@(posedge clk) disable iff (!rst_n)
        !ins_branch |-> !br_abs);

    a_r2_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (up && $past(pfx_wr) && dec_valid) |-> ext_imm[HI_W+LO_W-1:LO_W] == $past(pfx_byte));

    a_r3_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !$past(pfx_wr)) |-> ext_imm[HI_W+LO_W-1:LO_W] == '0);

    a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (ext_imm == '0 && ext_dst == '0 && ext_src == '0 && !br_abs));

    a_r7_dst_low: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ext_dst[DST_W-1:0] == ins_dst);

    a_r8_src_low: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ext_src[SRC_W-1:0] == ins_src);

    a_r3_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ext_imm[LO_W-1:0] == ins_imm);

endmodule

bind pfx_ext_unit pfx_ext_chk #(
    .LO_W(LO_W), .HI_W(HI_W), .DST_W(DST_W), .SRC_W(SRC_W), .IDX_W(IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .ins_branch (ins_branch),
    .ins_imm    (ins_imm),
    .ins_dst    (ins_dst),
    .ins_src    (ins_src),
    .pfx_wr     (pfx_wr),
    .pfx_byte   (pfx_byte),
    .ext_imm    (ext_imm),
    .ext_dst    (ext_dst),
    .ext_src    (ext_src),
    .br_abs     (br_abs)
);

// File: tb/sim_pfx_ext_unit.sv
`timescale 1ns/1ps
module sim_pfx_ext_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic        ins_branch = 1'b0;
    logic [7:0]  ins_imm = '0;
    logic [2:0]  ins_dst = '0;
    logic [3:0]  ins_src = '0;
    logic        pfx_wr = 1'b0;
    logic [7:0]  pfx_byte = '0;
    logic [3:0]  pfx_idx = '0;
    logic [15:0] ext_imm;
    logic [6:0]  ext_dst;
    logic [7:0]  ext_src;
    logic        br_abs;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pfx_ext_unit u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .ins_branch(ins_branch),
        .ins_imm(ins_imm), .ins_dst(ins_dst), .ins_src(ins_src),
        .pfx_wr(pfx_wr), .pfx_byte(pfx_byte), .pfx_idx(pfx_idx),
        .ext_imm(ext_imm), .ext_dst(ext_dst), .ext_src(ext_src), .br_abs(br_abs)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  pb;
        logic [3:0]  pi;
        logic        dv;
        logic        br;
        logic [7:0]  imm;
        logic [2:0]  dst;
        logic [3:0]  src;
        logic [15:0] e_imm;
        logic [6:0]  e_dst;
        logic [7:0]  e_src;
        logic        e_abs;
    } vec_t;

    // Each row: inputs of one cycle and outputs expected in that same cycle.
    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'h12, 4'h0, 1'b1, 1'b0, 8'h34, 3'd1, 4'h2, 16'h0034, 7'h01, 8'h02, 1'b0}, // R3 R9 write while consuming nothing
        '{1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 8'h34, 3'd1, 4'h2, 16'h1234, 7'h01, 8'h02, 1'b0}, // R2
        '{1'b0, 8'h00, 4'h0, 1'b1, 1'b1, 8'h56, 3'd0, 4'h0, 16'h0056, 7'h00, 8'h00, 1'b0}, // R4 R6
        '{1'b1, 8'h00, 4'h0, 1'b0, 1'b1, 8'h77, 3'd5, 4'h5, 16'h0000, 7'h00, 8'h00, 1'b0}, // R10
        '{1'b0, 8'h00, 4'h0, 1'b1, 1'b1, 8'h40, 3'd0, 4'h0, 16'h0040, 7'h00, 8'h00, 1'b1}, // R5 zero prefix
        '{1'b1, 8'hAB, 4'h5, 1'b1, 1'b0, 8'h11, 3'd7, 4'hF, 16'h0011, 7'h07, 8'h0F, 1'b0}, // R7 R8 zero-extend
        '{1'b1, 8'hCD, 4'h3, 1'b1, 1'b1, 8'h22, 3'd6, 4'h9, 16'hAB22, 7'h2E, 8'h59, 1'b1}, // R7 R8 R9
        '{1'b0, 8'h00, 4'h0, 1'b1, 1'b0, 8'h33, 3'd2, 4'h3, 16'hCD33, 7'h1A, 8'h33, 1'b0}, // R9 new kept
        '{1'b0, 8'h00, 4'h0, 1'b1, 1'b1, 8'h44, 3'd2, 4'h3, 16'h0044, 7'h02, 8'h03, 1'b0}, // R4 R6
        '{1'b1, 8'hFF, 4'hF, 1'b0, 1'b0, 8'h99, 3'd3, 4'h3, 16'h0000, 7'h00, 8'h00, 1'b0}, // R10
        '{1'b0, 8'h00, 4'h0, 1'b0, 1'b1, 8'h99, 3'd3, 4'h3, 16'h0000, 7'h00, 8'h00, 1'b0}, // R10 held but gated
        '{1'b0, 8'h00, 4'h0, 1'b1, 1'b1, 8'h55, 3'd1, 4'h1, 16'h0055, 7'h01, 8'h01, 1'b0}  // R4 expired unused
    };

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [7:0] pb, input logic [3:0] pi,
                         input logic dv, input logic br, input logic [7:0] imm,
                         input logic [2:0] dst, input logic [3:0] src);
        pfx_wr = wr; pfx_byte = pb; pfx_idx = pi;
        dec_valid = dv; ins_branch = br; ins_imm = imm; ins_dst = dst; ins_src = src;
    endtask

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        drive(1'b0, 8'h00, 4'h0, 1'b1, 1'b1, 8'h09, 3'd4, 4'h6);
        #1;
        chk("R1", "imm in reset", ext_imm, 16'h0009);
        chk("R1", "abs in reset", {15'd0, br_abs}, 16'h0000);
        chk("R1", "dst in reset", {9'd0, ext_dst}, 16'h0004);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].wr, TBL[i].pb, TBL[i].pi, TBL[i].dv, TBL[i].br,
                  TBL[i].imm, TBL[i].dst, TBL[i].src);
            #1;
            chk($sformatf("row%0d", i), "imm", ext_imm, TBL[i].e_imm);
            chk($sformatf("row%0d", i), "dst", {9'd0, ext_dst}, {9'd0, TBL[i].e_dst});
            chk($sformatf("row%0d", i), "src", {8'd0, ext_src}, {8'd0, TBL[i].e_src});
            chk($sformatf("row%0d", i), "abs", {15'd0, br_abs}, {15'd0, TBL[i].e_abs});
        end

        // R1: prefix written, then reset before use
        @(negedge clk);
        drive(1'b1, 8'hEE, 4'h7, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 8'h00, 4'h0, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 8'h00, 4'h0, 1'b1, 1'b1, 8'h66, 3'd5, 4'hA);
        #1;
        chk("R1", "imm after reset", ext_imm, 16'h0066);
        chk("R1", "abs after reset", {15'd0, br_abs}, 16'h0000);
        chk("R1", "src after reset", {8'd0, ext_src}, 16'h000A);

        // R5 R2: back-to-back prefixes, each applies to the next branch
        @(negedge clk);
        drive(1'b1, 8'h80, 4'hF, 1'b0, 1'b0, 8'h00, 3'd0, 4'h0);
        @(negedge clk);
        drive(1'b1, 8'h01, 4'h1, 1'b1, 1'b1, 8'h02, 3'd7, 4'hF);
        #1;
        chk("R5", "abs first", {15'd0, br_abs}, 16'h0001);
        chk("R2", "imm first", ext_imm, 16'h8002);
        chk("R7", "dst max", {9'd0, ext_dst}, 16'h007F);
        chk("R8", "src max", {8'd0, ext_src}, 16'h00FF);
        @(negedge clk);
        drive(1'b0, 8'h00, 4'h0, 1'b1, 1'b1, 8'h03, 3'd0, 4'h0);
        #1;
        chk("R5", "abs second", {15'd0, br_abs}, 16'h0001);
        chk("R2", "imm second", ext_imm, 16'h0103);
        @(negedge clk);
        #1;
        chk("R6", "abs expired", {15'd0, br_abs}, 16'h0000);
        chk("R4", "imm expired", ext_imm, 16'h0003);

        @(negedge clk);
        finish_up();
    end

endmodule